// File: doc/BRIEF.md
# Four-Position Character Display Write Controller

This controller sits between a host that produces characters and a four-position alphanumeric display that keeps each character in its own memory cell. The host presents a character position, a 7-bit ASCII code and a position-order select under a valid/ready handshake. The controller turns each accepted request into a complete write cycle on the display bus. The cycle has a setup phase with the strobe high, a strobe-low phase, and a hold phase with the strobe high. Digit address and data stay fixed through all three phases. Each phase lasts a parameterised number of clock cycles.

Positions may be written in any order. The display samples address and data on the rising edge of its active-low strobe, so no scan synchronisation is needed.

The display powers up with random contents. For this reason, after reset the controller writes ASCII space to digit addresses 0, 1, 2 and 3, in that order, before it accepts any host request.

The state machine has four states: IDLE, SETUP, PULSE and HOLD. It has five transitions:

- IDLE to SETUP on an accepted request.
- SETUP to PULSE when the setup count ends.
- PULSE to HOLD when the strobe-low count ends.
- HOLD to SETUP when the hold count ends during the clear sequence and more digits remain.
- HOLD to IDLE when the hold count ends otherwise.

Reset places the machine in SETUP for clear digit 0.

Top module: `disp4_wr_ctrl`

## Requirements
- R1: While reset is asserted, `req_ready` is low. After reset is released, the controller performs four writes of 0x20 to `dsp_addr` = 0, 1, 2, 3 in that order. Each write has the phase lengths given in R3 to R5. `req_ready` stays low throughout and goes high directly after the fourth hold phase.
- R2: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low from the cycle after acceptance until the hold phase has ended, and high again in the following cycle.
- R3: After acceptance, `dsp_wr_n` is high with the new address and data driven for exactly SETUP_CYC cycles.
- R4: `dsp_wr_n` is then low for exactly PULSE_CYC cycles.
- R5: After the strobe returns high, address and data remain unchanged for exactly HOLD_CYC cycles before the write ends.
- R6: `dsp_addr` and `dsp_data` do not change at any point from the start of a write's setup phase to the end of its hold phase.
- R7: With `order_ltr` = 0, `dsp_addr` equals `req_pos`. With `order_ltr` = 1, `dsp_addr` is the bitwise inverse of `req_pos`, so position 0 maps to address 3 and position 2 maps to address 1. `order_ltr` is sampled at acceptance.
- R8: `dsp_data[6:0]` equals `req_char[6:0]` bit for bit, with bit 6 as the MSB. Codes 0x00 and 0x7F pass unchanged.
- R9: A `req_valid` that is high while `req_ready` is low starts no write and has no effect. The address, data and strobe of the write in progress are unchanged, and none of them changes after that write ends.
- R10: `dsp_wr_n` is high during reset and whenever the controller is idle with `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host write request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_pos | input | POS_W | Host character position |
| req_char | input | CHAR_W | ASCII code to write |
| order_ltr | input | 1 | 1 selects inverted position order |
| dsp_addr | output | POS_W | Display digit address |
| dsp_data | output | CHAR_W | Display data bus |
| dsp_wr_n | output | 1 | Display write strobe, active low |

## Verification
A wrong state or a wrong phase count shows up at the ports within a single write. The low time of `dsp_wr_n` or the high time around it is off by cycles, or `req_ready` rises early or late. A wrong clear-sequence index shows up during the first four writes after reset, as a digit address out of order or a missing write. A wrong address or data latch shows as a bus value that differs from the request, or that moves while a write is in progress, in the cycle after the bad load.

// File: rtl/disp4_pkg.sv
package disp4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_PULSE = 2'd2,
        ST_HOLD  = 2'd3
    } wr_state_t;

endpackage

// File: rtl/disp4_phase_timer.sv
module disp4_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    assign done = (cnt_q == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < limit); // R4

endmodule

// File: rtl/disp4_pos_map.sv
module disp4_pos_map #(
    parameter int POS_W = 2
) (
    input  logic [POS_W-1:0] pos,
    input  logic             invert,
    output logic [POS_W-1:0] addr
);

    always_comb begin
        addr = invert ? ~pos : pos;
    end

endmodule

// File: rtl/disp4_clr_seq.sv
module disp4_clr_seq #(
    parameter int POS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic             active,
    output logic             last,
    output logic [POS_W-1:0] idx
);

    assign last = &idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (step && active) begin
            if (last) begin
                active <= 1'b0;
            end else begin
                idx <= idx + POS_W'(1);
            end
        end
    end

    AST_CLR_NEVER_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !active); // R1

endmodule

// File: rtl/disp4_wr_ctrl.sv
module disp4_wr_ctrl
    import disp4_pkg::*;
#(
    parameter int          POS_W     = 2,
    parameter int          CHAR_W    = 7,
    parameter int          SETUP_CYC = 2,
    parameter int          PULSE_CYC = 3,
    parameter int          HOLD_CYC  = 2,
    parameter logic [6:0]  CLR_CHAR  = 7'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [POS_W-1:0]  req_pos,
    input  logic [CHAR_W-1:0] req_char,
    input  logic              order_ltr,
    output logic [POS_W-1:0]  dsp_addr,
    output logic [CHAR_W-1:0] dsp_data,
    output logic              dsp_wr_n
);

    localparam int MAX_SP  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_CYC = (MAX_SP > HOLD_CYC) ? MAX_SP : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    wr_state_t         state_q;
    wr_state_t         state_nxt;
    logic [CNT_W-1:0]  phase_limit;
    logic              phase_done;
    logic              phase_restart;
    logic              accept;
    logic              clr_active;
    logic              clr_last;
    logic              clr_step;
    logic [POS_W-1:0]  clr_idx;
    logic [POS_W-1:0]  mapped_addr;

    assign accept        = req_valid && req_ready;
    assign clr_step      = (state_q == ST_HOLD) && phase_done && clr_active;
    assign phase_restart = (state_nxt != state_q);

    disp4_pos_map #(.POS_W(POS_W)) u_map (
        .pos    (req_pos),
        .invert (order_ltr),
        .addr   (mapped_addr)
    );

    disp4_clr_seq #(.POS_W(POS_W)) u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (clr_step),
        .active (clr_active),
        .last   (clr_last),
        .idx    (clr_idx)
    );

    disp4_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (phase_restart),
        .limit   (phase_limit),
        .done    (phase_done)
    );

    always_comb begin
        state_nxt   = state_q;
        phase_limit = CNT_W'(1);
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_nxt = ST_SETUP;
            end
            ST_SETUP: begin
                phase_limit = CNT_W'(SETUP_CYC);
                if (phase_done) state_nxt = ST_PULSE;
            end
            ST_PULSE: begin
                phase_limit = CNT_W'(PULSE_CYC);
                if (phase_done) state_nxt = ST_HOLD;
            end
            ST_HOLD: begin
                phase_limit = CNT_W'(HOLD_CYC);
                if (phase_done) begin
                    state_nxt = (clr_active && !clr_last) ? ST_SETUP : ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SETUP;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsp_wr_n  <= 1'b1;
            req_ready <= 1'b0;
            dsp_addr  <= '0;
            dsp_data  <= CHAR_W'(CLR_CHAR);
        end else begin
            dsp_wr_n  <= (state_nxt != ST_PULSE);
            req_ready <= (state_nxt == ST_IDLE);
            if (accept) begin
                dsp_addr <= mapped_addr;
                dsp_data <= req_char;
            end else if (clr_step && !clr_last) begin
                dsp_addr <= clr_idx + POS_W'(1);
                dsp_data <= CHAR_W'(CLR_CHAR);
            end
        end
    end

    AST_IDLE_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> dsp_wr_n); // R10

    AST_BUS_STABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !dsp_wr_n |-> ($stable(dsp_addr) && $stable(dsp_data))); // R6

    AST_HOLD_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!dsp_wr_n) && dsp_wr_n) |-> ($stable(dsp_addr) && $stable(dsp_data))); // R5

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready); // R2

    AST_CLEAR_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_active |-> !req_ready); // R1

    AST_BUSY_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> $stable(dsp_data)); // R9

endmodule

// File: tb/disp4_wr_ctrl_bench.sv
`timescale 1ns/1ps
module disp4_wr_ctrl_bench;

    localparam int S = 2;
    localparam int P = 3;
    localparam int H = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_pos = '0;
    logic [6:0] req_char = '0;
    logic       order_ltr = 1'b0;
    logic [1:0] dsp_addr;
    logic [6:0] dsp_data;
    logic       dsp_wr_n;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    disp4_wr_ctrl #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) u_disp4_wr_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_pos(req_pos), .req_char(req_char), .order_ltr(order_ltr),
        .dsp_addr(dsp_addr), .dsp_data(dsp_data), .dsp_wr_n(dsp_wr_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Observes one write starting at the current negedge; leaves off at the
    // first negedge after its hold phase.
    task automatic run_seq(input logic [1:0] ea, input logic [6:0] ed,
                           input bit host, input string tag);
        int hi = 0, lo = 0, hold = 0, busy_bad = 0, bus_bad = 0;
        while (dsp_wr_n && hi < 40) begin
            if (dsp_addr != ea || dsp_data != ed) bus_bad++;
            if (req_ready) busy_bad++;
            hi++; @(negedge clk);
        end
        while (!dsp_wr_n && lo < 40) begin
            if (dsp_addr != ea || dsp_data != ed) bus_bad++;
            if (req_ready) busy_bad++;
            lo++; @(negedge clk);
        end
        while (dsp_wr_n && dsp_addr == ea && !req_ready && hold < 40) begin
            if (dsp_data != ed) bus_bad++;
            hold++; @(negedge clk);
        end
        check(hi == S, {tag, " R3 setup cycles"}, hi, S);
        check(lo == P, {tag, " R4 strobe low cycles"}, lo, P);
        check(hold == H, {tag, " R5 hold cycles"}, hold, H);
        check(bus_bad == 0, {tag, " R6 bus stable/values"}, bus_bad, 0);
        check(busy_bad == 0, {tag, " R2 ready low while busy"}, busy_bad, 0);
        if (host) check(req_ready == 1'b1, {tag, " R2 ready after hold"}, req_ready, 1);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(dsp_wr_n == 1'b1, "R10 strobe high in reset", dsp_wr_n, 1);
        check(req_ready == 1'b0, "R1 ready low in reset", req_ready, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            run_seq(2'(k), 7'h20, 1'b0, $sformatf("R1 clear digit %0d", k));
        end
        check(req_ready == 1'b1, "R1 ready after clear", req_ready, 1);
        check(dsp_addr == 2'd3, "R1 last clear address", dsp_addr, 3);
    endtask

    task automatic t_write(input logic [1:0] pos, input logic [6:0] ch,
                           input bit ltr, input logic [1:0] ea, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_pos = pos; req_char = ch; order_ltr = ltr;
        @(negedge clk);
        req_valid = 1'b0; order_ltr = ~ltr;
        run_seq(ea, ch, 1'b1, tag);
        check(dsp_addr == ea, {tag, " R7 address"}, dsp_addr, ea);
        check(dsp_data == ch, {tag, " R8 data"}, dsp_data, ch);
    endtask

    task automatic t_busy();
        @(negedge clk);
        req_valid = 1'b1; req_pos = 2'd1; req_char = 7'h41; order_ltr = 1'b0;
        @(negedge clk);
        req_pos = 2'd2; req_char = 7'h5A; order_ltr = 1'b1;
        run_seq(2'd1, 7'h41, 1'b1, "R9 busy");
        req_valid = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check(dsp_wr_n == 1'b1 && dsp_addr == 2'd1 && dsp_data == 7'h41,
                  "R9 no write from ignored request", {dsp_wr_n, dsp_addr, dsp_data}, {1'b1, 2'd1, 7'h41});
        end
    endtask

    task automatic t_idle();
        repeat (5) begin
            @(negedge clk);
            check(dsp_wr_n == 1'b1 && req_ready == 1'b1, "R10 idle strobe high",
                  dsp_wr_n, 1);
        end
    endtask

    initial begin
        t_reset();
        t_write(2'd0, 7'h48, 1'b0, 2'd0, "R7 rtl pos0");
        t_write(2'd3, 7'h49, 1'b0, 2'd3, "R7 rtl pos3");
        t_write(2'd0, 7'h4C, 1'b1, 2'd3, "R7 ltr pos0");
        t_write(2'd2, 7'h4D, 1'b1, 2'd1, "R7 ltr pos2");
        t_write(2'd1, 7'h7F, 1'b0, 2'd1, "R8 code 7F");
        t_write(2'd2, 7'h00, 1'b0, 2'd2, "R8 code 00");
        t_busy();
        t_idle();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule